// File: doc/BRIEF.md
# UART Register-Access Target Bridge

This block is the target side of a serial debug and configuration link. It sits behind a byte-wide receive and transmit interface. Each side uses a valid/ready handshake, and the serializer and baud generator lie outside the block. The block turns framed commands into accesses on a 32-bit internal register and memory port. A host can use it to read and write single registers, to move blocks of bytes in either direction, to hand a new baud divisor to the serializer, and to probe whether a target is present.

A command frame always has the same fixed length of thirteen bytes and is protected by an XOR checksum. The bridge answers every accepted frame with a one-byte acknowledge before any payload moves. The link is half duplex: while the bridge is transmitting, it accepts no input. In block transfers, bytes are packed little-endian into 32-bit words. Each word touched is read or written once, and byte strobes cover partial words at either end of the transfer.

Top module: `uart_reg_bridge`

## Requirements
- R1: While idle, the received byte 0x12 is answered with the single byte 0x5A. Any other idle byte except 0xA5 produces no output and no access. Input is never accepted while a byte is being offered for transmission.
- R2: A frame is 0xA5 followed by 12 bytes. Byte 1 is the command code and bytes 3-4 a 16-bit byte count. Bytes 5-8 are a 32-bit address and bytes 9-12 a 32-bit data word, each field least significant byte first. Byte 2 must equal the XOR of bytes 1 and 3 through 12. A valid frame is answered with one 0xAC.
- R3: A frame with a wrong checksum, or with a code other than 0, 1, 2, 3 or 5, gets no reply and makes no access. The next 0x12 or 0xA5 is handled normally.
- R4: Code 1 makes one write of the data field with all four byte strobes set. The write goes to the address with bits 1:0 cleared and follows the acknowledge.
- R5: Code 0 makes one read of the address with bits 1:0 cleared. After the acknowledge it returns the word as 4 bytes, most significant byte first.
- R6: Code 2 returns, after the acknowledge, exactly count bytes taken from successive byte addresses. Byte address A is lane A[1:0] of the word at A with bits 1:0 cleared. There is one read per word touched. A count of 0 returns only the acknowledge.
- R7: Code 3 takes count payload bytes after the acknowledge. Each byte goes to successive byte addresses, using the same lane mapping as R6. Each word touched is written once, and its strobe bit i is set only for bytes placed in lane i. A second 0xAC follows the last payload byte; with a count of 0 it follows the first at once.
- R8: Code 5 raises baudStrobe for exactly one cycle, right after the acknowledge handshake, with baudDivisor equal to the data field. It makes no register access.
- R9: regWe and regRe are never high in the same cycle.
- R10: While txValid is high and txReady low, txValid stays high and txData stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxValid | input | 1 | Received byte is present |
| rxData | input | 8 | Received byte |
| rxReady | output | 1 | Bridge takes the received byte this cycle |
| txValid | output | 1 | Byte offered for transmission |
| txData | output | 8 | Byte to transmit |
| txReady | input | 1 | Serializer takes the offered byte |
| regAddr | output | 32 | Word-aligned access address |
| regWdata | output | 32 | Write data |
| regStrb | output | 4 | Byte strobes of a write, bit i for bits 8i+7:8i |
| regWe | output | 1 | Write enable, one cycle per write |
| regRe | output | 1 | Read enable; data is expected on regRdata the next cycle |
| regRdata | input | 32 | Read data |
| baudStrobe | output | 1 | One-cycle pulse for a new divisor |
| baudDivisor | output | 32 | New divisor, valid with baudStrobe |

## Verification
Single-register accesses are run at an aligned and at an unaligned address. This separates correct clearing of the low address bits from use of the raw address, and most-significant-first return order from lane order. Block transfers start mid-word and end mid-word, so the strobe masks of the partial first and last words are exposed against preloaded guard bytes. A zero-count block read tests that only the acknowledge comes back. Corrupted checksums, an unknown code and stray idle bytes each show that a frame is dropped without stalling the parser. Random transmit stalls during reads show that output bytes are held and never lost or repeated.

// File: rtl/urb_pkg.sv
package urb_pkg;
  localparam int FRAME_LEN = 13;
  localparam logic [7:0] SYNC_BYTE   = 8'hA5;
  localparam logic [7:0] PROBE_BYTE  = 8'h12;
  localparam logic [7:0] PROBE_REPLY = 8'h5A;
  localparam logic [7:0] ACK_BYTE    = 8'hAC;
  localparam logic [7:0] CMD_RD   = 8'd0;
  localparam logic [7:0] CMD_WR   = 8'd1;
  localparam logic [7:0] CMD_BRD  = 8'd2;
  localparam logic [7:0] CMD_BWR  = 8'd3;
  localparam logic [7:0] CMD_BAUD = 8'd5;

  typedef enum logic [1:0] {TX_PROBE, TX_ACK, TX_DATA} txSel_e;

  typedef enum logic [3:0] {
    S_HUNT, S_PROBE, S_HDR, S_CHECK, S_ACK, S_WRREG,
    S_RDREQ, S_RDWAIT, S_SEND, S_WRRX, S_ACK2, S_BAUD
  } state_e;

  typedef struct packed {
    logic   clrHdr;
    logic   takeHdr;
    logic   startXfer;
    logic   wrReg;
    logic   latchRd;
    logic   advTx;
    logic   takeWr;
    txSel_e txSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/urb_ctrl.sv
module urb_ctrl
  import urb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  logic        txReady,
  input  logic        hdrLast,
  input  logic        frameOk,
  input  logic [7:0]  cmdCode,
  input  logic        blkZero,
  input  logic        cntOne,
  input  logic        laneLast,
  output ctrlStrobe_t strobe,
  output logic        rxReady,
  output logic        txValid,
  output logic        regRe,
  output logic        baudStrobe
);
  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_HUNT;
    else       state <= nextState;
  end

  always_comb begin
    nextState  = state;
    strobe     = '0;
    strobe.txSel = TX_DATA;
    rxReady    = 1'b0;
    txValid    = 1'b0;
    regRe      = 1'b0;
    baudStrobe = 1'b0;
    unique case (state)
      S_HUNT: begin
        rxReady = 1'b1;
        if (rxValid) begin
          if (rxData == PROBE_BYTE) nextState = S_PROBE;
          else if (rxData == SYNC_BYTE) begin
            strobe.clrHdr = 1'b1;
            nextState = S_HDR;
          end
        end
      end
      S_PROBE: begin
        txValid = 1'b1;
        strobe.txSel = TX_PROBE;
        if (txReady) nextState = S_HUNT;
      end
      S_HDR: begin
        rxReady = 1'b1;
        if (rxValid) begin
          strobe.takeHdr = 1'b1;
          if (hdrLast) nextState = S_CHECK;
        end
      end
      S_CHECK: nextState = frameOk ? S_ACK : S_HUNT;
      S_ACK: begin
        txValid = 1'b1;
        strobe.txSel = TX_ACK;
        if (txReady) begin
          strobe.startXfer = 1'b1;
          case (cmdCode)
            CMD_RD:  nextState = S_RDREQ;
            CMD_WR:  nextState = S_WRREG;
            CMD_BRD: nextState = blkZero ? S_HUNT : S_RDREQ;
            CMD_BWR: nextState = blkZero ? S_ACK2 : S_WRRX;
            default: nextState = S_BAUD;
          endcase
        end
      end
      S_WRREG: begin
        strobe.wrReg = 1'b1;
        nextState = S_HUNT;
      end
      S_RDREQ: begin
        regRe = 1'b1;
        nextState = S_RDWAIT;
      end
      S_RDWAIT: begin
        strobe.latchRd = 1'b1;
        nextState = S_SEND;
      end
      S_SEND: begin
        txValid = 1'b1;
        if (txReady) begin
          strobe.advTx = 1'b1;
          if (cntOne) nextState = S_HUNT;
          else if (cmdCode == CMD_BRD && laneLast) nextState = S_RDREQ;
        end
      end
      S_WRRX: begin
        rxReady = 1'b1;
        if (rxValid) begin
          strobe.takeWr = 1'b1;
          if (cntOne) nextState = S_ACK2;
        end
      end
      S_ACK2: begin
        txValid = 1'b1;
        strobe.txSel = TX_ACK;
        if (txReady) nextState = S_HUNT;
      end
      S_BAUD: begin
        baudStrobe = 1'b1;
        nextState = S_HUNT;
      end
      default: nextState = S_HUNT;
    endcase
  end
endmodule

// File: rtl/urb_datapath.sv
module urb_datapath
  import urb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [7:0]          rxData,
  input  logic [DATA_W-1:0]   regRdata,
  output logic [ADDR_W-1:0]   regAddr,
  output logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W/8-1:0] regStrb,
  output logic                regWe,
  output logic [7:0]          txData,
  output logic [DATA_W-1:0]   baudDivisor,
  output logic                hdrLast,
  output logic                frameOk,
  output logic [7:0]          cmdCode,
  output logic                blkZero,
  output logic                cntOne,
  output logic                laneLast
);
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int IDX_W  = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [IDX_W-1:0]  idx;
  logic [7:0]        csAcc;
  logic [CNT_W-1:0]  blkCnt, cnt;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dataFld, word, wbuf, merged;
  logic [LANES-1:0]  wstrb, mstrb;
  logic [LANE_W-1:0] lane, rdLane;
  logic              flush, codeKnown;

  assign lane     = addr[LANE_W-1:0];
  assign rdLane   = cnt[LANE_W-1:0] - LANE_W'(1);
  assign laneLast = (lane == {LANE_W{1'b1}});
  assign cntOne   = (cnt == CNT_W'(1));
  assign blkZero  = (blkCnt == '0);
  assign hdrLast  = (idx == LAST_IDX);
  assign codeKnown = (cmdCode == CMD_RD) || (cmdCode == CMD_WR) || (cmdCode == CMD_BRD) ||
                     (cmdCode == CMD_BWR) || (cmdCode == CMD_BAUD);
  assign frameOk  = (csAcc == 8'h00) && codeKnown;

  always_comb begin
    merged = wbuf;
    merged[8*lane +: 8] = rxData;
    mstrb = wstrb;
    mstrb[lane] = 1'b1;
  end
  assign flush = laneLast || cntOne;

  assign regAddr     = {addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
  assign regWe       = strobe.wrReg || (strobe.takeWr && flush);
  assign regWdata    = strobe.wrReg ? dataFld : merged;
  assign regStrb     = strobe.wrReg ? {LANES{1'b1}} : mstrb;
  assign baudDivisor = dataFld;

  always_comb begin
    unique case (strobe.txSel)
      TX_PROBE: txData = PROBE_REPLY;
      TX_ACK:   txData = ACK_BYTE;
      default:  txData = (cmdCode == CMD_RD) ? word[8*rdLane +: 8] : word[8*lane +: 8];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0; csAcc <= '0; cmdCode <= '0; blkCnt <= '0; cnt <= '0;
      addr <= '0; dataFld <= '0; word <= '0; wbuf <= '0; wstrb <= '0;
    end else begin
      if (strobe.clrHdr) begin
        idx   <= IDX_W'(1);
        csAcc <= '0;
      end
      if (strobe.takeHdr) begin
        idx   <= idx + IDX_W'(1);
        csAcc <= csAcc ^ rxData;
        case (idx)
          IDX_W'(1): cmdCode <= rxData;
          IDX_W'(3): blkCnt[7:0]  <= rxData;
          IDX_W'(4): blkCnt[15:8] <= rxData;
          IDX_W'(5), IDX_W'(6), IDX_W'(7), IDX_W'(8):
            addr[8*(idx - IDX_W'(5)) +: 8] <= rxData;
          IDX_W'(9), IDX_W'(10), IDX_W'(11), IDX_W'(12):
            dataFld[8*(idx - IDX_W'(9)) +: 8] <= rxData;
          default: ;
        endcase
      end
      if (strobe.startXfer) begin
        cnt   <= (cmdCode == CMD_RD) ? CNT_W'(LANES) : blkCnt;
        wstrb <= '0;
      end
      if (strobe.latchRd) word <= regRdata;
      if (strobe.advTx) begin
        cnt <= cnt - CNT_W'(1);
        if (cmdCode != CMD_RD) addr <= addr + ADDR_W'(1);
      end
      if (strobe.takeWr) begin
        cnt  <= cnt - CNT_W'(1);
        addr <= addr + ADDR_W'(1);
        wbuf <= merged;
        wstrb <= flush ? '0 : mstrb;
      end
    end
  end
endmodule

// File: rtl/uart_reg_bridge.sv
module uart_reg_bridge
  import urb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rxValid,
  input  logic [7:0]          rxData,
  output logic                rxReady,
  output logic                txValid,
  output logic [7:0]          txData,
  input  logic                txReady,
  output logic [ADDR_W-1:0]   regAddr,
  output logic [DATA_W-1:0]   regWdata,
  output logic [DATA_W/8-1:0] regStrb,
  output logic                regWe,
  output logic                regRe,
  input  logic [DATA_W-1:0]   regRdata,
  output logic                baudStrobe,
  output logic [DATA_W-1:0]   baudDivisor
);
  ctrlStrobe_t strobe;
  logic hdrLast, frameOk, blkZero, cntOne, laneLast;
  logic [7:0] cmdCode;

  urb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .txReady(txReady),
    .hdrLast(hdrLast), .frameOk(frameOk), .cmdCode(cmdCode), .blkZero(blkZero),
    .cntOne(cntOne), .laneLast(laneLast), .strobe(strobe), .rxReady(rxReady),
    .txValid(txValid), .regRe(regRe), .baudStrobe(baudStrobe)
  );

  urb_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxData(rxData), .regRdata(regRdata),
    .regAddr(regAddr), .regWdata(regWdata), .regStrb(regStrb), .regWe(regWe),
    .txData(txData), .baudDivisor(baudDivisor), .hdrLast(hdrLast), .frameOk(frameOk),
    .cmdCode(cmdCode), .blkZero(blkZero), .cntOne(cntOne), .laneLast(laneLast)
  );
endmodule

// File: rtl/uart_reg_bridge_chk.sv
module uart_reg_bridge_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rxReady,
  input logic       txValid,
  input logic [7:0] txData,
  input logic       txReady,
  input logic [3:0] regStrb,
  input logic       regWe,
  input logic       regRe,
  input logic       baudStrobe
);
  p_half_duplex_r1: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !rxReady);
  p_rd_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    regRe |=> (!regRe && !txValid));
  p_strobe_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    regWe |-> ($countones(regStrb) > 0));
  p_baud_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    baudStrobe |=> !baudStrobe);
  p_baud_after_ack_r8: assert property (@(posedge clk) disable iff (!rstN)
    baudStrobe |-> $past(txValid && txReady && (txData == 8'hAC)));
  p_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(regWe && regRe));
  p_tx_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData)));
endmodule

bind uart_reg_bridge uart_reg_bridge_chk u_chk (
  .clk(clk), .rstN(rstN), .rxReady(rxReady), .txValid(txValid), .txData(txData),
  .txReady(txReady), .regStrb(regStrb), .regWe(regWe), .regRe(regRe),
  .baudStrobe(baudStrobe)
);

// File: tb/uart_reg_bridge_tb.sv
module uart_reg_bridge_tb;
  logic clk = 1'b0, rstN = 1'b0;
  logic rxValid = 1'b0, txReady = 1'b1;
  logic [7:0] rxData = '0, txData;
  logic rxReady, txValid, regWe, regRe, baudStrobe;
  logic [31:0] regAddr, regWdata, regRdata = '0, baudDivisor;
  logic [3:0] regStrb;

  uart_reg_bridge u_dut (
    .clk(clk), .rstN(rstN), .rxValid(rxValid), .rxData(rxData), .rxReady(rxReady),
    .txValid(txValid), .txData(txData), .txReady(txReady), .regAddr(regAddr),
    .regWdata(regWdata), .regStrb(regStrb), .regWe(regWe), .regRe(regRe),
    .regRdata(regRdata), .baudStrobe(baudStrobe), .baudDivisor(baudDivisor)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0, stallEn = 0;
  string curReq = "R1";
  logic [7:0] expQ[$];
  logic [7:0] mem8[logic [31:0]];
  logic [7:0] exp8[logic [31:0]];
  int weCnt = 0, reCnt = 0, baudHits = 0;
  logic [31:0] baudExp = '0;
  logic [7:0] lfsr = 8'h5B;
  logic holdPend = 0;
  logic [7:0] holdByte;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdMem(logic [31:0] a);
    return mem8.exists(a) ? mem8[a] : 8'h00;
  endfunction
  function automatic logic [7:0] rdExp(logic [31:0] a);
    return exp8.exists(a) ? exp8[a] : 8'h00;
  endfunction

  // bench memory: registered read data, strobed byte writes
  always @(posedge clk) begin
    if (regWe) begin
      weCnt++;
      for (int i = 0; i < 4; i++)
        if (regStrb[i]) mem8[regAddr + 32'(i)] = regWdata[8*i +: 8];
    end
    if (regRe) begin
      reCnt++;
      regRdata <= {rdMem(regAddr + 3), rdMem(regAddr + 2), rdMem(regAddr + 1), rdMem(regAddr)};
    end
  end

  // per-clock reference comparison of the transmit side
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    txReady = stallEn ? (lfsr[0] | lfsr[3]) : 1'b1;
    #1;
    if (holdPend && txValid) chk("R10", "held tx byte", {24'h0, txData}, {24'h0, holdByte});
    holdPend = 0;
    if (txValid && rxReady) chk("R1", "rx accepted while transmitting", 1, 0);
    if (regWe && regRe) chk("R9", "write and read together", 1, 0);
    if (txValid && txReady) begin
      if (expQ.size() == 0) chk(curReq, "unexpected tx byte", {24'h0, txData}, 32'hFFFF_FFFF);
      else chk(curReq, "tx byte", {24'h0, txData}, {24'h0, expQ.pop_front()});
    end else if (txValid) begin
      holdPend = 1;
      holdByte = txData;
    end
    if (baudStrobe) begin
      baudHits++;
      chk("R8", "baud divisor", baudDivisor, baudExp);
      chk("R8", "ack done before strobe", expQ.size(), 0);
    end
  end

  task automatic sendByte(logic [7:0] b);
    @(negedge clk);
    rxValid = 1'b1;
    rxData = b;
    while (!rxReady) @(negedge clk);
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  task automatic sendFrame(logic [7:0] code, logic [15:0] n, logic [31:0] a, logic [31:0] d, bit bad);
    logic [7:0] b[13];
    logic [7:0] cs;
    b[0] = 8'hA5; b[1] = code; b[2] = 8'h00; b[3] = n[7:0]; b[4] = n[15:8];
    for (int i = 0; i < 4; i++) begin
      b[5+i] = a[8*i +: 8];
      b[9+i] = d[8*i +: 8];
    end
    cs = 8'h00;
    for (int i = 1; i < 13; i++) cs ^= b[i];
    b[2] = bad ? (cs ^ 8'h40) : cs;
    for (int i = 0; i < 13; i++) sendByte(b[i]);
  endtask

  task automatic waitIdle(string req);
    for (int i = 0; i < 400 && expQ.size() != 0; i++) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(req, "pending expected bytes", expQ.size(), 0);
  endtask

  task automatic pushRead(logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    for (int i = 3; i >= 0; i--) expQ.push_back(rdExp(w + 32'(i)));
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem8[32'h200 + 32'(i)] = 8'hEE;
      exp8[32'h200 + 32'(i)] = 8'hEE;
      mem8[32'h100 + 32'(i)] = 8'(8'h30 + i);
      exp8[32'h100 + 32'(i)] = 8'(8'h30 + i);
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "reset rxReady", rxReady, 1);
    chk("R1", "reset txValid", txValid, 0);
    chk("R9", "reset regWe/regRe", {regWe, regRe}, 0);
    chk("R8", "reset baudStrobe", baudStrobe, 0);

    curReq = "R1";
    expQ.push_back(8'h5A);
    sendByte(8'h12);
    waitIdle("R1");
    sendByte(8'h33);
    sendByte(8'h00);
    waitIdle("R1");

    curReq = "R4";
    weCnt = 0;
    expQ.push_back(8'hAC);
    sendFrame(8'd1, 16'h0, 32'h0000_0010, 32'hDEAD_BEEF, 0);
    waitIdle("R2");
    for (int i = 0; i < 4; i++) exp8[32'h10 + 32'(i)] = 8'(32'hDEAD_BEEF >> (8*i));
    chk("R4", "write count", weCnt, 1);
    chk("R4", "written word", {rdMem(32'h13), rdMem(32'h12), rdMem(32'h11), rdMem(32'h10)}, 32'hDEAD_BEEF);

    curReq = "R5";
    stallEn = 1;
    reCnt = 0;
    expQ.push_back(8'hAC);
    pushRead(32'h10);
    sendFrame(8'd0, 16'h0, 32'h0000_0010, 32'h0, 0);
    waitIdle("R5");
    expQ.push_back(8'hAC);
    pushRead(32'h13);
    sendFrame(8'd0, 16'h0, 32'h0000_0013, 32'h0, 0);
    waitIdle("R5");
    chk("R5", "read count", reCnt, 2);

    curReq = "R3";
    weCnt = 0; reCnt = 0;
    sendFrame(8'd1, 16'h0, 32'h0000_0040, 32'h1234_5678, 1);
    waitIdle("R3");
    sendFrame(8'd4, 16'h0, 32'h0000_0040, 32'h1234_5678, 0);
    waitIdle("R3");
    sendFrame(8'd0, 16'h0, 32'h0000_0010, 32'h0, 1);
    waitIdle("R3");
    chk("R3", "accesses from dropped frames", weCnt + reCnt, 0);
    expQ.push_back(8'h5A);
    sendByte(8'h12);
    waitIdle("R3");

    curReq = "R7";
    weCnt = 0;
    expQ.push_back(8'hAC);
    sendFrame(8'd3, 16'd6, 32'h0000_0201, 32'h0, 0);
    for (int i = 0; i < 6; i++) begin
      sendByte(8'(8'hA0 + i));
      exp8[32'h201 + 32'(i)] = 8'(8'hA0 + i);
    end
    expQ.push_back(8'hAC);
    waitIdle("R7");
    chk("R7", "block write count", weCnt, 2);
    for (int i = 0; i < 12; i++)
      chk("R7", "block write byte", {24'h0, rdMem(32'h1FE + 32'(i))}, {24'h0, rdExp(32'h1FE + 32'(i))});
    expQ.push_back(8'hAC);
    expQ.push_back(8'hAC);
    sendFrame(8'd3, 16'd0, 32'h0000_0300, 32'h0, 0);
    waitIdle("R7");

    curReq = "R6";
    reCnt = 0;
    expQ.push_back(8'hAC);
    for (int i = 0; i < 7; i++) expQ.push_back(rdExp(32'h102 + 32'(i)));
    sendFrame(8'd2, 16'd7, 32'h0000_0102, 32'h0, 0);
    waitIdle("R6");
    chk("R6", "block read count", reCnt, 3);
    reCnt = 0;
    expQ.push_back(8'hAC);
    sendFrame(8'd2, 16'd0, 32'h0000_0100, 32'h0, 0);
    waitIdle("R6");
    chk("R6", "zero-count reads", reCnt, 0);

    curReq = "R8";
    weCnt = 0; reCnt = 0; baudHits = 0;
    baudExp = 32'h0001_C200;
    expQ.push_back(8'hAC);
    sendFrame(8'd5, 16'h0, 32'h0, 32'h0001_C200, 0);
    waitIdle("R8");
    chk("R8", "strobe count", baudHits, 1);
    chk("R8", "accesses during baud", weCnt + reCnt, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule